// File: doc/BRIEF.md
# Two-Wire Wiper Command Slave

This block is the serial front end of a digitally controlled potentiometer. A fast system clock oversamples the SCL and SDA lines of a two-wire bus. Each line passes through a synchronizer and a glitch filter, and the block then finds start conditions, stop conditions and clock edges. After a start it takes in an identification byte and compares it with a fixed device type and three address pins. It then takes in an instruction byte, which picks one of the command formats: read or write the wiper register, read or write a stored data register, move a value between a data register and the wiper, or step the wiper.

The block never holds wiper or register values itself. It passes each decoded command to an adjacent register controller as a one-cycle `cmd_valid` pulse. Read data is requested with `rd_req` and returned on `rd_data`. The slave answers on SDA only by pulling the line low through `sda_oe`, which is an open-drain enable. While the controller reports a nonvolatile write with `nv_busy`, the slave leaves its address unacknowledged, so a bus master can poll until the write has finished.

Top module: `digipot_twi_slave`

## Requirements
- R1: A start condition (SDA falls while SCL is high) restarts reception of the identification byte from any state, including a repeated start. A stop condition (SDA rises while SCL is high) returns the slave to idle with `sda_oe` low.
- R2: The identification byte is received MSB first as type[3:0], then a zero bit, then the address bits [2:0]. The type must be 0101 and the address must equal `dev_addr`. On a match the slave pulls SDA low during the ninth clock. On any mismatch it stays silent for the rest of the transaction.
- R3: While `nv_busy` is high, even a matching identification byte receives no acknowledge.
- R4: The instruction byte is op[3:0], reg[1:0], bank[1:0], MSB first. The defined opcodes are 1001, 1010, 1011, 1100, 1101, 1110 and 0010. Opcodes 1011 and 1100 accept any bank. All others need bank 00. Any other instruction gets no acknowledge and issues no command.
- R5: Opcode 1010 takes in a data byte, acknowledges it, and issues `cmd_kind`=1 (wiper write) carrying that byte when the acknowledge starts.
- R6: Opcode 1100 takes in and acknowledges a data byte, then issues `cmd_kind`=2 (data register write), with reg, bank and data, only at the terminating stop.
- R7: Opcodes 1101 and 1110 are two bytes long. At the terminating stop they issue `cmd_kind`=3 (register to wiper) or 4 (wiper to register), with the selected reg.
- R8: Opcodes 1001 (wiper) and 1011 (register) pulse `rd_req` when the instruction acknowledge starts, with `rd_dr`=0 or 1 and `cmd_reg`/`cmd_bank` set. The slave loads `rd_data` at the falling edge that ends that acknowledge. It then sends the 8 bits MSB first, each changing after an SCL falling edge, and releases SDA for the master's acknowledge.
- R9: Opcode 0010 enters step mode. Each later SCL pulse issues `cmd_kind`=5 (up) if SDA was high while SCL was high, or 6 (down) if it was low. The step is issued at the falling edge of SCL. The stop that ends the mode issues no step.
- R10: A pulse on SCL shorter than `FILT_CYC` system clocks has no effect.
- R11: A stop in the middle of a byte abandons it. The bits received so far issue no command, and the next transaction works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pulls SDA low when high (open drain) |
| dev_addr | input | 3 | Address pins compared with identification bits [2:0] |
| nv_busy | input | 1 | Controller is in a nonvolatile write |
| rd_data | input | 8 | Value returned by the controller for a read |
| rd_req | output | 1 | One-cycle read request |
| rd_dr | output | 1 | Read source: 1 data register, 0 wiper |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 3 | Command code (1..6, see requirements) |
| cmd_reg | output | 2 | Selected register |
| cmd_bank | output | 2 | Selected bank |
| cmd_data | output | 8 | Data byte of a write command |

## Verification
The bench builds the block with `FILT_CYC`=4, the 0101 device type and address pins tied to 101. It runs SCL with 20-clock half periods. The filter, edge detector and FSM together respond within about ten clocks, which leaves time for the master to turn SDA around before the next SCL edge. A 2-clock SCL pulse is half the filter window, so with this setting the glitch rejection can be tested directly. The bench's controller model holds its busy flag for 2500 clocks, which is several identification bytes long, so both the refused address and the later acknowledge can be observed.

// File: rtl/digipot_twi_pkg.sv
package digipot_twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID_RX,
        ST_ID_ACK,
        ST_INS_RX,
        ST_INS_ACK,
        ST_DAT_RX,
        ST_DAT_ACK,
        ST_DAT_TX,
        ST_MACK,
        ST_STEP,
        ST_HOLD
    } fsm_st_e;

    typedef enum logic [2:0] {
        CK_NONE   = 3'd0,
        CK_WR_WCR = 3'd1,
        CK_WR_DR  = 3'd2,
        CK_DR2WCR = 3'd3,
        CK_WCR2DR = 3'd4,
        CK_STEP_UP = 3'd5,
        CK_STEP_DN = 3'd6
    } cmd_kind_e;

    localparam logic [3:0] OP_RD_WCR = 4'b1001;
    localparam logic [3:0] OP_WR_WCR = 4'b1010;
    localparam logic [3:0] OP_RD_DR  = 4'b1011;
    localparam logic [3:0] OP_WR_DR  = 4'b1100;
    localparam logic [3:0] OP_DR2WCR = 4'b1101;
    localparam logic [3:0] OP_WCR2DR = 4'b1110;
    localparam logic [3:0] OP_STEP   = 4'b0010;

    typedef struct packed {
        logic      ok;
        logic      three;
        logic      rd;
        logic      rd_dr;
        logic      step;
        cmd_kind_e kind;
    } ins_dec_t;

    function automatic ins_dec_t decode_ins(input logic [7:0] ins);
        ins_dec_t d;
        logic     bank0;
        bank0 = (ins[1:0] == 2'b00);
        d = '{ok: 1'b0, three: 1'b0, rd: 1'b0, rd_dr: 1'b0, step: 1'b0, kind: CK_NONE};
        unique case (ins[7:4])
            OP_RD_WCR: begin d.ok = bank0; d.rd = 1'b1; end
            OP_WR_WCR: begin d.ok = bank0; d.three = 1'b1; d.kind = CK_WR_WCR; end
            OP_RD_DR:  begin d.ok = 1'b1; d.rd = 1'b1; d.rd_dr = 1'b1; end
            OP_WR_DR:  begin d.ok = 1'b1; d.three = 1'b1; d.kind = CK_WR_DR; end
            OP_DR2WCR: begin d.ok = bank0; d.kind = CK_DR2WCR; end
            OP_WCR2DR: begin d.ok = bank0; d.kind = CK_WCR2DR; end
            OP_STEP:   begin d.ok = bank0; d.step = 1'b1; end
            default:   d.ok = 1'b0;
        endcase
        return d;
    endfunction

    typedef struct packed {
        fsm_st_e    st;
        logic [7:0] sh;
        logic [3:0] cnt;
        logic [7:0] ins;
        logic [7:0] dat;
        cmd_kind_e  pend;
        logic [7:0] tx;
        logic       dir;
        logic       oe;
        logic       cmd_valid;
        cmd_kind_e  cmd_kind;
        logic [1:0] cmd_reg;
        logic [1:0] cmd_bank;
        logic [7:0] cmd_data;
        logic       rd_req;
        logic       rd_dr;
    } fsm_regs_t;

    localparam fsm_regs_t FSM_RST = '{
        st: ST_IDLE, sh: 8'h00, cnt: 4'h0, ins: 8'h00, dat: 8'h00,
        pend: CK_NONE, tx: 8'h00, dir: 1'b0, oe: 1'b0, cmd_valid: 1'b0,
        cmd_kind: CK_NONE, cmd_reg: 2'b00, cmd_bank: 2'b00, cmd_data: 8'h00,
        rd_req: 1'b0, rd_dr: 1'b0
    };

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t q, n;

    always_comb begin
        n    = q;
        n.s1 = raw_i;
        n.s2 = q.s1;
        if (q.s2 == q.filt) begin
            n.cnt = '0;
        end else if (q.cnt == CNT_LAST) begin
            n.filt = q.s2;
            n.cnt  = '0;
        end else begin
            n.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: 1'b1, s2: 1'b1, filt: 1'b1, cnt: '0};
        else        q <= n;
    end

    assign filt_o = q.filt;

    AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.filt) |-> ($past(q.s2) == q.filt)); // R10

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic sda_lvl
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } ev_t;

    ev_t q, n;

    always_comb begin
        n.scl_p = scl_f;
        n.sda_p = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scl_p: 1'b1, sda_p: 1'b1};
        else        q <= n;
    end

    assign scl_rise  = scl_f & ~q.scl_p;
    assign scl_fall  = ~scl_f & q.scl_p;
    assign start_evt = q.scl_p & scl_f & q.sda_p & ~sda_f;
    assign stop_evt  = q.scl_p & scl_f & ~q.sda_p & sda_f;
    assign sda_lvl   = sda_f;

endmodule

// File: rtl/digipot_cmd_fsm.sv
module digipot_cmd_fsm
    import digipot_twi_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE = 4'b0101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       sda_lvl,
    input  logic [2:0] dev_addr,
    input  logic       nv_busy,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       rd_req,
    output logic       rd_dr,
    output logic       cmd_valid,
    output logic [2:0] cmd_kind,
    output logic [1:0] cmd_reg,
    output logic [1:0] cmd_bank,
    output logic [7:0] cmd_data
);
    localparam logic [3:0] BITS = 4'd8;

    fsm_regs_t q, n;
    ins_dec_t  dec_sh, dec_ins;

    always_comb begin
        dec_sh  = decode_ins(q.sh);
        dec_ins = decode_ins(q.ins);
        n           = q;
        n.cmd_valid = 1'b0;
        n.cmd_kind  = CK_NONE;
        n.rd_req    = 1'b0;

        if (start_evt) begin
            n.st   = ST_ID_RX;
            n.cnt  = 4'd0;
            n.oe   = 1'b0;
            n.pend = CK_NONE;
        end else if (stop_evt) begin
            if (q.st == ST_HOLD && q.pend != CK_NONE) begin
                n.cmd_valid = 1'b1;
                n.cmd_kind  = q.pend;
                n.cmd_reg   = q.ins[3:2];
                n.cmd_bank  = q.ins[1:0];
                n.cmd_data  = q.dat;
            end
            n.st   = ST_IDLE;
            n.cnt  = 4'd0;
            n.oe   = 1'b0;
            n.pend = CK_NONE;
        end else begin
            unique case (q.st)
                ST_ID_RX, ST_INS_RX, ST_DAT_RX: begin
                    if (scl_rise && q.cnt != BITS) begin
                        n.sh  = {q.sh[6:0], sda_lvl};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BITS) begin
                        n.cnt = 4'd0;
                        if (q.st == ST_ID_RX) begin
                            if (q.sh[7:4] == DEV_TYPE && !q.sh[3] &&
                                q.sh[2:0] == dev_addr && !nv_busy) begin
                                n.st = ST_ID_ACK;
                                n.oe = 1'b1;
                            end else begin
                                n.st = ST_HOLD;
                            end
                        end else if (q.st == ST_INS_RX) begin
                            n.ins = q.sh;
                            if (dec_sh.ok) begin
                                n.st = ST_INS_ACK;
                                n.oe = 1'b1;
                                if (dec_sh.rd) begin
                                    n.rd_req   = 1'b1;
                                    n.rd_dr    = dec_sh.rd_dr;
                                    n.cmd_reg  = q.sh[3:2];
                                    n.cmd_bank = q.sh[1:0];
                                end
                            end else begin
                                n.st = ST_HOLD;
                            end
                        end else begin
                            n.dat = q.sh;
                            n.st  = ST_DAT_ACK;
                            n.oe  = 1'b1;
                            if (dec_ins.kind == CK_WR_WCR) begin
                                n.cmd_valid = 1'b1;
                                n.cmd_kind  = CK_WR_WCR;
                                n.cmd_reg   = q.ins[3:2];
                                n.cmd_bank  = q.ins[1:0];
                                n.cmd_data  = q.sh;
                            end else begin
                                n.pend = dec_ins.kind;
                            end
                        end
                    end
                end
                ST_ID_ACK: begin
                    if (scl_fall) begin
                        n.oe  = 1'b0;
                        n.st  = ST_INS_RX;
                        n.cnt = 4'd0;
                    end
                end
                ST_INS_ACK: begin
                    if (scl_fall) begin
                        n.oe  = 1'b0;
                        n.cnt = 4'd0;
                        if (dec_ins.rd) begin
                            n.tx = rd_data;
                            n.oe = ~rd_data[7];
                            n.st = ST_DAT_TX;
                        end else if (dec_ins.three) begin
                            n.st = ST_DAT_RX;
                        end else if (dec_ins.step) begin
                            n.st = ST_STEP;
                        end else begin
                            n.pend = dec_ins.kind;
                            n.st   = ST_HOLD;
                        end
                    end
                end
                ST_DAT_ACK: begin
                    if (scl_fall) begin
                        n.oe = 1'b0;
                        n.st = ST_HOLD;
                    end
                end
                ST_DAT_TX: begin
                    if (scl_rise) begin
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == BITS) begin
                            n.oe = 1'b0;
                            n.st = ST_MACK;
                        end else begin
                            n.tx = {q.tx[6:0], 1'b0};
                            n.oe = ~q.tx[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_fall) n.st = ST_HOLD;
                end
                ST_STEP: begin
                    if (scl_rise) begin
                        n.dir = sda_lvl;
                        n.cnt = 4'd1;
                    end else if (scl_fall && q.cnt == 4'd1) begin
                        n.cnt       = 4'd0;
                        n.cmd_valid = 1'b1;
                        n.cmd_kind  = q.dir ? CK_STEP_UP : CK_STEP_DN;
                        n.cmd_reg   = q.ins[3:2];
                        n.cmd_bank  = q.ins[1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FSM_RST;
        else        q <= n;
    end

    assign sda_oe    = q.oe;
    assign rd_req    = q.rd_req;
    assign rd_dr     = q.rd_dr;
    assign cmd_valid = q.cmd_valid;
    assign cmd_kind  = q.cmd_kind;
    assign cmd_reg   = q.cmd_reg;
    assign cmd_bank  = q.cmd_bank;
    assign cmd_data  = q.cmd_data;

    AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !start_evt) |=> !q.oe); // R1

    AST_BUSY_NO_ID_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ID_RX && scl_fall && q.cnt == BITS && nv_busy && !start_evt && !stop_evt)
        |=> (!q.oe && q.st == ST_HOLD)); // R3

    AST_OE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> $past(scl_fall || start_evt || stop_evt)); // R8

    AST_STEP_ONLY_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd_valid && (q.cmd_kind == CK_STEP_UP || q.cmd_kind == CK_STEP_DN))
        |-> ($past(q.st) == ST_STEP)); // R9

endmodule

// File: rtl/digipot_twi_slave.sv
module digipot_twi_slave
    import digipot_twi_pkg::*;
#(
    parameter int         FILT_CYC = 4,
    parameter logic [3:0] DEV_TYPE = 4'b0101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] dev_addr,
    input  logic       nv_busy,
    input  logic [7:0] rd_data,
    output logic       rd_req,
    output logic       rd_dr,
    output logic       cmd_valid,
    output logic [2:0] cmd_kind,
    output logic [1:0] cmd_reg,
    output logic [1:0] cmd_bank,
    output logic [7:0] cmd_data
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] filt_lines;
    logic scl_rise, scl_fall, start_evt, stop_evt, sda_lvl;

    assign raw_lines = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            twi_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_i  (raw_lines[g]),
                .filt_o (filt_lines[g])
            );
        end
    endgenerate

    twi_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (filt_lines[0]),
        .sda_f     (filt_lines[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_lvl   (sda_lvl)
    );

    digipot_cmd_fsm #(.DEV_TYPE(DEV_TYPE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_lvl   (sda_lvl),
        .dev_addr  (dev_addr),
        .nv_busy   (nv_busy),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .rd_req    (rd_req),
        .rd_dr     (rd_dr),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_reg   (cmd_reg),
        .cmd_bank  (cmd_bank),
        .cmd_data  (cmd_data)
    );

endmodule

// File: tb/digipot_twi_slave_bench.sv
module digipot_twi_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int BUSY_CLK   = 2500;
    localparam int WD_CYC     = 190000;
    localparam logic [2:0] ADDR  = 3'b101;
    localparam logic [7:0] ID_OK = {4'b0101, 1'b0, ADDR};
    localparam int NVEC = 10;
    // {write instruction, data, expected instruction ack, read instruction, expected value}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'hA0, 8'h5A, 8'h01, 8'h90, 8'h5A},
        {8'hC8, 8'h33, 8'h01, 8'hB8, 8'h33},
        {8'hC7, 8'h7E, 8'h01, 8'hB7, 8'h7E},
        {8'hD8, 8'h00, 8'h01, 8'h90, 8'h33},
        {8'hA0, 8'hC4, 8'h01, 8'h90, 8'hC4},
        {8'hE4, 8'h00, 8'h01, 8'hB4, 8'hC4},
        {8'hF0, 8'h00, 8'h00, 8'h90, 8'hC4},
        {8'hD9, 8'h00, 8'h00, 8'h90, 8'hC4},
        {8'hC0, 8'h99, 8'h01, 8'hB0, 8'h99},
        {8'hD0, 8'h00, 8'h01, 8'h90, 8'h99}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic scl_m, sda_m;
    logic sda_line;
    logic sda_oe, rd_req, rd_dr, cmd_valid, nv_busy;
    logic [2:0] cmd_kind;
    logic [1:0] cmd_reg, cmd_bank;
    logic [7:0] cmd_data, rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // controller model
    logic [7:0] wcr;
    logic [7:0] dr [16];
    int busy_cnt;
    int cmd_cnt, up_cnt, dn_cnt;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;
    assign nv_busy  = (busy_cnt != 0);

    digipot_twi_slave u_digipot_twi_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .dev_addr(ADDR), .nv_busy(nv_busy), .rd_data(rd_data), .rd_req(rd_req),
        .rd_dr(rd_dr), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_reg(cmd_reg),
        .cmd_bank(cmd_bank), .cmd_data(cmd_data)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            wcr <= 8'h00; busy_cnt <= 0; rd_data <= 8'h00;
            cmd_cnt <= 0; up_cnt <= 0; dn_cnt <= 0;
            for (int i = 0; i < 16; i++) dr[i] <= 8'h00;
        end else begin
            if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
            if (rd_req) rd_data <= rd_dr ? dr[{cmd_bank, cmd_reg}] : wcr;
            if (cmd_valid) begin
                cmd_cnt <= cmd_cnt + 1;
                case (cmd_kind)
                    3'd1: wcr <= cmd_data;
                    3'd2: begin dr[{cmd_bank, cmd_reg}] <= cmd_data; busy_cnt <= BUSY_CLK; end
                    3'd3: wcr <= dr[{2'b00, cmd_reg}];
                    3'd4: begin dr[{2'b00, cmd_reg}] <= wcr; busy_cnt <= BUSY_CLK; end
                    3'd5: begin up_cnt <= up_cnt + 1; if (wcr != 8'hFF) wcr <= wcr + 8'd1; end
                    3'd6: begin dn_cnt <= dn_cnt + 1; if (wcr != 8'h00) wcr <= wcr - 8'd1; end
                    default: ;
                endcase
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic do_stop;
        tick(Q); sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        tick(Q); sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        tick(Q); sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            tick(Q); sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            tick(Q); scl_m = 1'b0;
        end
        tick(Q); sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        check(sda_oe == 1'b0, "R8 release for master ack", sda_oe, 0);
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic poll_ready;
        logic ack;
        int tries;
        tries = 0;
        ack = 1'b0;
        while (!ack && tries < 60) begin
            do_start; send_byte(ID_OK, ack); do_stop;
            tries++;
        end
        check(ack, "R3 polling ends with ack", ack, 1);
    endtask

    task automatic read_txn(input logic [7:0] ins, output logic [7:0] val);
        logic a;
        do_start;
        send_byte(ID_OK, a);
        send_byte(ins, a);
        recv_byte(val);
        do_stop;
    endtask

    initial begin
        int c0, u0, d0;
        logic a, a2;
        logic [7:0] v;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        tick(5);
        check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
        check(cmd_valid == 1'b0, "R1 reset cmd_valid", cmd_valid, 0);
        rst_n = 1'b1;
        tick(20);

        // vector table: write then read back
        for (int k = 0; k < NVEC; k++) begin
            logic [7:0] wi, wd, ri, ev;
            logic ea;
            wi = VEC[k][39:32]; wd = VEC[k][31:24]; ea = VEC[k][16];
            ri = VEC[k][15:8];  ev = VEC[k][7:0];
            c0 = cmd_cnt;
            do_start;
            send_byte(ID_OK, a);
            check(a, "R2 id ack", a, 1);
            send_byte(wi, a);
            check(a == ea, "R4 instruction ack", a, ea);
            if (a && (wi[7:4] == 4'hA || wi[7:4] == 4'hC)) begin
                send_byte(wd, a2);
                check(a2, "R5 R6 data ack", a2, 1);
            end
            do_stop;
            tick(4 * Q);
            if (!ea) check(cmd_cnt == c0, "R4 no command on nack", cmd_cnt - c0, 0);
            poll_ready;
            read_txn(ri, v);
            check(v == ev, "R5 R6 R7 R8 readback", v, ev);
        end

        // wrong address and wrong type bit
        c0 = cmd_cnt;
        do_start; send_byte({4'b0101, 1'b0, 3'b100}, a);
        check(!a, "R2 wrong address nack", a, 0);
        send_byte(8'hA0, a);
        check(!a, "R2 ignored after mismatch", a, 0);
        do_stop;
        do_start; send_byte({4'b0101, 1'b1, ADDR}, a);
        check(!a, "R2 nonzero bit3 nack", a, 0);
        do_stop;
        tick(4 * Q);
        check(cmd_cnt == c0, "R2 no command", cmd_cnt - c0, 0);

        // busy polling after a register write
        do_start; send_byte(ID_OK, a); send_byte(8'hC5, a); send_byte(8'h42, a); do_stop;
        do_start; send_byte(ID_OK, a);
        check(!a, "R3 busy nack", a, 0);
        do_stop;
        poll_ready;
        read_txn(8'hB5, v);
        check(v == 8'h42, "R6 write on stop", v, 8'h42);

        // step mode with a glitch
        do_start; send_byte(ID_OK, a); send_byte(8'hA0, a); send_byte(8'h10, a); do_stop;
        u0 = up_cnt; d0 = dn_cnt;
        do_start; send_byte(ID_OK, a); send_byte(8'h20, a);
        check(a, "R9 step opcode ack", a, 1);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        tick(Q); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q);
        do_stop;
        tick(4 * Q);
        check(up_cnt - u0 == 3, "R9 up steps", up_cnt - u0, 3);
        check(dn_cnt - d0 == 1, "R9 R10 down steps no glitch", dn_cnt - d0, 1);
        read_txn(8'h90, v);
        check(v == 8'h12, "R9 wiper after steps", v, 8'h12);

        // stop in the middle of the instruction byte
        c0 = cmd_cnt;
        do_start; send_byte(ID_OK, a);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        do_stop;
        tick(4 * Q);
        check(sda_oe == 1'b0, "R11 idle after stop", sda_oe, 0);
        check(cmd_cnt == c0, "R11 no command", cmd_cnt - c0, 0);
        read_txn(8'h90, v);
        check(v == 8'h12, "R11 recovery read", v, 8'h12);

        // repeated start after the id byte
        do_start; send_byte(ID_OK, a);
        read_txn(8'h90, v);
        check(v == 8'h12, "R1 repeated start", v, 8'h12);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule